// File: doc/BRIEF.md
# DMA Element Transfer Engine with Descriptor Reload

This block moves one element of data for a DMA channel that an arbiter has already chosen. The arbiter presents the channel's working state in a single grant: source address, destination address, next-descriptor pointer, control word and enable flag. The engine then reads source data through a simple request/response memory port and packs it into one destination-width unit. It writes that unit out in destination-width pieces and steps the addresses as the control word asks. It then decrements the element count held in the control word.

When the count reaches zero, the engine does one of two things. If the next-descriptor pointer is nonzero, it loads a fresh four-word descriptor from memory. If the pointer is zero, it clears the channel's enable. The finished channel state is handed back to the channel register file in a single write-back cycle. In that same cycle a terminal-count event is pulsed if the final control word asks for one. The engine handles one grant at a time and reports itself busy until the write-back has been issued.

Top module: `dmae_element_engine`

## Requirements
- R1: The source width code is control bits 20:18 and the destination width code is control bits 23:21. A code of 0 means 1 byte, 1 means 2 bytes, and any code of 2 or above is clamped to 4 bytes (the bus width). `mem_req_size` carries the clamped code: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes.
- R2: For each element the engine issues at least one source read of the source width. It keeps issuing such reads until the destination width in bytes has been gathered. Each response contributes its lowest source-width bytes, placed at the next free byte of an assembly buffer.
- R3: When control bit 26 is set, the source address advances by the source width after every read. When bit 26 is clear, every read uses the same address and the written-back source address is unchanged.
- R4: The engine writes max(source width, destination width) bytes in pieces of the destination width, taken from the assembly buffer in byte order. Each piece sits in the low lanes of `mem_req_wdata`, with the unused upper lanes zero. When control bit 27 is set, the destination address advances by the destination width after every write; otherwise all writes use the same address.
- R5: After the element, the count in control bits 11:0 is one lower, and control bits 31:12 are unchanged.
- R6: A grant whose count is already zero causes no memory request. The state is written back unchanged and no terminal-count event is raised.
- R7: When the count becomes zero and the pointer is nonzero, four word reads (size code 2) are issued at pointer+0, +4, +12 and +8, in that order. They load the source address, destination address, control word and new pointer respectively. The enable flag is kept.
- R8: When the count becomes zero and the pointer is zero, no descriptor read is issued and the written-back enable is 0. In every other case the enable is written back as granted.
- R9: `tc_pulse` is high, with `tc_chan` equal to the granted channel, only in the write-back cycle of an element whose count became zero and whose resulting control word (after any reload) has bit 31 set.
- R10: A grant is accepted on a clock edge where `gnt_valid` and `gnt_ready` are both high. `gnt_ready` is high only while idle. `busy` is high from the cycle after acceptance through the single write-back cycle, and low again the cycle after.
- R11: A memory request that is not accepted (`mem_req_ready` low) stays valid with the same address, direction and size on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnt_valid | input | 1 | A granted channel is presented |
| gnt_ready | output | 1 | Engine idle and able to take a grant |
| gnt_chan | input | CH_W | Granted channel number |
| gnt_src | input | AW | Channel source address |
| gnt_dst | input | AW | Channel destination address |
| gnt_lli | input | AW | Channel next-descriptor pointer |
| gnt_ctrl | input | 32 | Channel control word |
| gnt_en | input | 1 | Channel enable flag |
| busy | output | 1 | Element in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_size | output | 2 | Access size code (R1 encoding) |
| mem_req_wdata | output | 32 | Write data in the low lanes |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| wb_valid | output | 1 | One-cycle write-back of channel state |
| wb_chan | output | CH_W | Channel being written back |
| wb_src | output | AW | Updated source address |
| wb_dst | output | AW | Updated destination address |
| wb_lli | output | AW | Updated next-descriptor pointer |
| wb_ctrl | output | 32 | Updated control word |
| wb_en | output | 1 | Updated enable flag |
| tc_pulse | output | 1 | Terminal-count event |
| tc_chan | output | CH_W | Channel raising the event |

## Verification
Two functions meet in one cycle: the terminal-count event and the write-back of a channel state that has just been replaced by a fetched descriptor. The bench provokes this by granting a count of one with a nonzero pointer whose descriptor carries bit 31 in its control word, and it stalls the memory port during the fetch. It then judges that `tc_pulse` rises exactly with `wb_valid`, that the written-back fields are the fetched words, and that a reloaded descriptor without bit 31 produces a write-back with no event.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;
  localparam int CNT_W     = 12;
  localparam int OFF_W     = 4;

  localparam int CTL_SW_LO = 18;
  localparam int CTL_DW_LO = 21;
  localparam int CTL_SINC  = 26;
  localparam int CTL_DINC  = 27;
  localparam int CTL_TCREQ = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RWAIT,
    ST_WRITE,
    ST_UPDATE,
    ST_DFETCH,
    ST_DWAIT,
    ST_DONE
  } eng_state_t;

  // Width code clamped to the bus width (code 2 = 4 bytes).
  function automatic logic [1:0] clamp_code(input logic [2:0] code);
    return (code > 3'd2) ? 2'd2 : code[1:0];
  endfunction

  function automatic logic [OFF_W-1:0] code_bytes(input logic [1:0] code);
    return OFF_W'(1) << code;
  endfunction

  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] cnt);
    return cnt - CNT_W'(1);
  endfunction

  // Descriptor word offsets in fetch order: src, dst, ctrl, next pointer.
  function automatic logic [3:0] desc_offset(input logic [1:0] idx);
    case (idx)
      2'd0:    return 4'd0;
      2'd1:    return 4'd4;
      2'd2:    return 4'd12;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dmae_pack_buf.sv
module dmae_pack_buf
  import dmae_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ins_en,
  input  logic [BUS_W-1:0] ins_data,
  input  logic [OFF_W-1:0] ins_off,
  input  logic [OFF_W-1:0] ins_bytes,
  input  logic [OFF_W-1:0] ext_off,
  input  logic [OFF_W-1:0] ext_bytes,
  output logic [BUS_W-1:0] ext_data
);

  logic [BUS_W-1:0] buf_q;
  logic [BUS_W-1:0] merged;

  always_comb begin
    merged = buf_q;
    for (int lane = 0; lane < BUS_BYTES; lane++) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (k < int'(ins_bytes) && lane == int'(ins_off) + k)
          merged[lane*8 +: 8] = ins_data[k*8 +: 8];
      end
    end
  end

  always_comb begin
    ext_data = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (j < int'(ext_bytes) && k == int'(ext_off) + j)
          ext_data[j*8 +: 8] = buf_q[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (clear)  buf_q <= '0;
    else if (ins_en) buf_q <= merged;
  end

endmodule

// File: rtl/dmae_desc_seq.sv
module dmae_desc_seq
  import dmae_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step,
  output logic [1:0] idx,
  output logic [3:0] offset,
  output logic       last
);

  logic [1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= 2'd0;
    else if (start) idx_q <= 2'd0;
    else if (step)  idx_q <= idx_q + 2'd1;
  end

  assign idx    = idx_q;
  assign offset = desc_offset(idx_q);
  assign last   = (idx_q == 2'd3);

endmodule

// File: rtl/dmae_element_engine.sv
module dmae_element_engine
  import dmae_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt_valid,
  output logic            gnt_ready,
  input  logic [CH_W-1:0] gnt_chan,
  input  logic [AW-1:0]   gnt_src,
  input  logic [AW-1:0]   gnt_dst,
  input  logic [AW-1:0]   gnt_lli,
  input  logic [31:0]     gnt_ctrl,
  input  logic            gnt_en,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [1:0]      mem_req_size,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            wb_valid,
  output logic [CH_W-1:0] wb_chan,
  output logic [AW-1:0]   wb_src,
  output logic [AW-1:0]   wb_dst,
  output logic [AW-1:0]   wb_lli,
  output logic [31:0]     wb_ctrl,
  output logic            wb_en,
  output logic            tc_pulse,
  output logic [CH_W-1:0] tc_chan
);

  eng_state_t       st_q;
  logic [CH_W-1:0]  chan_q;
  logic [AW-1:0]    src_q, dst_q, lli_q;
  logic [31:0]      ctrl_q;
  logic             en_q;
  logic [OFF_W-1:0] off_q;
  logic             zero_hit_q;

  // Named internal events
  logic             grant_take;
  logic             elem_rsp;
  logic             desc_rsp;
  logic             read_fill_done;
  logic             write_cover_done;
  logic             count_exhausted;

  logic [1:0]       sw_code, dw_code;
  logic [OFF_W-1:0] sw_bytes, dw_bytes, cover_bytes;
  logic [CNT_W-1:0] cnt_next;
  logic [BUS_W-1:0] pack_out;
  logic [1:0]       d_idx;
  logic [3:0]       d_off;
  logic             d_last;

  assign sw_code     = clamp_code(ctrl_q[CTL_SW_LO +: 3]);
  assign dw_code     = clamp_code(ctrl_q[CTL_DW_LO +: 3]);
  assign sw_bytes    = code_bytes(sw_code);
  assign dw_bytes    = code_bytes(dw_code);
  assign cover_bytes = (sw_bytes > dw_bytes) ? sw_bytes : dw_bytes;
  assign cnt_next    = count_after(ctrl_q[CNT_W-1:0]);

  assign grant_take       = (st_q == ST_IDLE) && gnt_valid;
  assign elem_rsp         = (st_q == ST_RWAIT) && mem_rsp_valid;
  assign desc_rsp         = (st_q == ST_DWAIT) && mem_rsp_valid;
  assign read_fill_done   = elem_rsp && ((off_q + sw_bytes) >= dw_bytes);
  assign write_cover_done = (st_q == ST_WRITE) && mem_req_ready &&
                            ((off_q + dw_bytes) >= cover_bytes);
  assign count_exhausted  = (st_q == ST_UPDATE) && (cnt_next == '0);

  dmae_pack_buf u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (grant_take),
    .ins_en    (elem_rsp),
    .ins_data  (mem_rsp_data),
    .ins_off   (off_q),
    .ins_bytes (sw_bytes),
    .ext_off   (off_q),
    .ext_bytes (dw_bytes),
    .ext_data  (pack_out)
  );

  dmae_desc_seq u_desc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (st_q == ST_UPDATE),
    .step   (desc_rsp),
    .idx    (d_idx),
    .offset (d_off),
    .last   (d_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      chan_q     <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      lli_q      <= '0;
      ctrl_q     <= '0;
      en_q       <= 1'b0;
      off_q      <= '0;
      zero_hit_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (gnt_valid) begin
            chan_q     <= gnt_chan;
            src_q      <= gnt_src;
            dst_q      <= gnt_dst;
            lli_q      <= gnt_lli;
            ctrl_q     <= gnt_ctrl;
            en_q       <= gnt_en;
            off_q      <= '0;
            zero_hit_q <= 1'b0;
            st_q       <= (gnt_ctrl[CNT_W-1:0] == '0) ? ST_DONE : ST_READ;
          end
        end
        ST_READ: begin
          if (mem_req_ready) st_q <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mem_rsp_valid) begin
            if (ctrl_q[CTL_SINC]) src_q <= src_q + AW'(sw_bytes);
            if (read_fill_done) begin
              off_q <= '0;
              st_q  <= ST_WRITE;
            end else begin
              off_q <= off_q + sw_bytes;
              st_q  <= ST_READ;
            end
          end
        end
        ST_WRITE: begin
          if (mem_req_ready) begin
            if (ctrl_q[CTL_DINC]) dst_q <= dst_q + AW'(dw_bytes);
            off_q <= off_q + dw_bytes;
            if (write_cover_done) st_q <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          ctrl_q[CNT_W-1:0] <= cnt_next;
          if (count_exhausted) begin
            zero_hit_q <= 1'b1;
            if (lli_q != '0) begin
              st_q <= ST_DFETCH;
            end else begin
              en_q <= 1'b0;
              st_q <= ST_DONE;
            end
          end else begin
            st_q <= ST_DONE;
          end
        end
        ST_DFETCH: begin
          if (mem_req_ready) st_q <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (mem_rsp_valid) begin
            case (d_idx)
              2'd0:    src_q  <= AW'(mem_rsp_data);
              2'd1:    dst_q  <= AW'(mem_rsp_data);
              2'd2:    ctrl_q <= mem_rsp_data;
              default: lli_q  <= AW'(mem_rsp_data);
            endcase
            st_q <= d_last ? ST_DONE : ST_DFETCH;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_size  = 2'd0;
    mem_req_wdata = '0;
    case (st_q)
      ST_READ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_q;
        mem_req_size  = sw_code;
      end
      ST_WRITE: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_q;
        mem_req_size  = dw_code;
        mem_req_wdata = pack_out;
      end
      ST_DFETCH: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = lli_q + AW'(d_off);
        mem_req_size  = 2'd2;
      end
      default: ;
    endcase
  end

  assign gnt_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign wb_valid  = (st_q == ST_DONE);
  assign wb_chan   = chan_q;
  assign wb_src    = src_q;
  assign wb_dst    = dst_q;
  assign wb_lli    = lli_q;
  assign wb_ctrl   = ctrl_q;
  assign wb_en     = en_q;
  assign tc_pulse  = (st_q == ST_DONE) && zero_hit_q && ctrl_q[CTL_TCREQ];
  assign tc_chan   = chan_q;

endmodule

// File: rtl/dmae_element_engine_chk.sv
module dmae_element_engine_chk #(
  parameter int AW   = 32,
  parameter int CH_W = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_size,
  input logic [31:0]   mem_req_wdata,
  input logic          wb_valid,
  input logic [31:0]   wb_ctrl,
  input logic          tc_pulse
);

  // R11: a stalled request is held unchanged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_size));

  // R9: event only together with write-back of a control word requesting it
  p_tc_with_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> wb_valid && wb_ctrl[31]);

  // R10: write-back lasts one cycle and the engine is then idle
  p_wb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid && !busy);

  // R10: memory traffic only while busy
  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R4: a one-byte write keeps its upper lanes zero
  p_byte_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && mem_req_size == 2'd0 |-> mem_req_wdata[31:8] == 24'd0);

  // R1: size code never exceeds the bus width
  p_size_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size != 2'd3);

endmodule

bind dmae_element_engine dmae_element_engine_chk #(.AW(AW), .CH_W(CH_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_wdata (mem_req_wdata),
  .wb_valid      (wb_valid),
  .wb_ctrl       (wb_ctrl),
  .tc_pulse      (tc_pulse)
);

// File: tb/dmae_element_engine_tb_top.sv
module dmae_element_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CH_W = 3;

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
    string       req;
  } req_t;

  typedef struct {
    logic [CH_W-1:0] chan;
    logic [31:0] src, dst, lli, ctrl;
    logic        en;
    logic        tc;
  } wb_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt_valid = 1'b0;
  logic gnt_ready;
  logic [CH_W-1:0] gnt_chan = '0;
  logic [AW-1:0] gnt_src = '0, gnt_dst = '0, gnt_lli = '0;
  logic [31:0] gnt_ctrl = '0;
  logic gnt_en = 1'b0;
  logic busy;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [1:0] mem_req_size;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic wb_valid, wb_en, tc_pulse;
  logic [CH_W-1:0] wb_chan, tc_chan;
  logic [AW-1:0] wb_src, wb_dst, wb_lli;
  logic [31:0] wb_ctrl;

  dmae_element_engine #(.AW(AW), .CH_W(CH_W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int wb_seen = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit rd_pending = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [7:0] mem_b [0:1023];
  req_t exp_req[$];
  wb_t  exp_wb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = mem_b[(a + k) & 32'h3ff];
    return w;
  endfunction

  task automatic put_word(input logic [31:0] a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem_b[(a + k) & 32'h3ff] = w[k*8 +: 8];
  endtask

  // Predictor: builds expected requests and write-back from the requirements.
  task automatic predict(input logic [CH_W-1:0] ch, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] lli,
                         input logic [31:0] ctrl, input logic en);
    int sc, dc, swb, dwb, xs, n;
    logic [7:0] bb [4];
    logic [31:0] s, d, data, c;
    wb_t w;
    req_t r;
    w.chan = ch; w.src = src; w.dst = dst; w.lli = lli; w.ctrl = ctrl; w.en = en; w.tc = 1'b0;
    if (ctrl[11:0] != 12'd0) begin
      sc = int'(ctrl[20:18]); if (sc > 2) sc = 2;
      dc = int'(ctrl[23:21]); if (dc > 2) dc = 2;
      swb = 1 << sc; dwb = 1 << dc;
      for (int k = 0; k < 4; k++) bb[k] = 8'h00;
      n = 0; s = src;
      do begin
        r.wr = 0; r.addr = s; r.size = 2'(sc); r.data = 0; r.req = "R2/R3 source read";
        exp_req.push_back(r);
        for (int k = 0; k < swb; k++) bb[n+k] = mem_b[(s + k) & 32'h3ff];
        n += swb;
        if (ctrl[26]) s += swb;
      end while (n < dwb);
      xs = (swb > dwb) ? swb : dwb;
      d = dst;
      for (int off = 0; off < xs; off += dwb) begin
        data = 0;
        for (int k = 0; k < dwb; k++) data[k*8 +: 8] = bb[off+k];
        r.wr = 1; r.addr = d; r.size = 2'(dc); r.data = data; r.req = "R4 destination write";
        exp_req.push_back(r);
        if (ctrl[27]) d += dwb;
      end
      c = ctrl; c[11:0] = ctrl[11:0] - 12'd1;
      w.src = s; w.dst = d; w.ctrl = c;
      if (c[11:0] == 12'd0) begin
        if (lli != 0) begin
          for (int i = 0; i < 4; i++) begin
            r.wr = 0; r.size = 2'd2; r.data = 0; r.req = "R7 descriptor fetch";
            r.addr = lli + ((i == 0) ? 0 : (i == 1) ? 4 : (i == 2) ? 12 : 8);
            exp_req.push_back(r);
          end
          w.src = rd_word(lli); w.dst = rd_word(lli + 4);
          w.ctrl = rd_word(lli + 12); w.lli = rd_word(lli + 8);
        end else begin
          w.en = 1'b0;
        end
        w.tc = w.ctrl[31];
      end
    end
    exp_wb.push_back(w);
  endtask

  // Driver: presents one grant and waits for its write-back.
  task automatic run(input logic [CH_W-1:0] ch, input logic [31:0] src,
                     input logic [31:0] dst, input logic [31:0] lli,
                     input logic [31:0] ctrl);
    int prev;
    predict(ch, src, dst, lli, ctrl, 1'b1);
    prev = wb_seen;
    @(negedge clk);
    chk(gnt_ready === 1'b1, "R10", "ready when idle", 32'(gnt_ready), 32'd1);
    gnt_valid = 1'b1; gnt_chan = ch; gnt_src = src; gnt_dst = dst;
    gnt_lli = lli; gnt_ctrl = ctrl; gnt_en = 1'b1;
    @(negedge clk);
    gnt_valid = 1'b0;
    chk(busy === 1'b1, "R10", "busy after grant", 32'(busy), 32'd1);
    chk(gnt_ready === 1'b0, "R10", "not ready while busy", 32'(gnt_ready), 32'd0);
    wait (wb_seen == prev + 1);
    @(negedge clk);
    chk(busy === 1'b0, "R10", "idle after write-back", 32'(busy), 32'd0);
    chk(exp_req.size() == 0, "R6", "all predicted requests seen", 32'(exp_req.size()), 32'd0);
  endtask

  // Memory model and monitor, all at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rd_pending) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd_word(pend_addr);
        rd_pending    = 1'b0;
      end
      mem_req_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (exp_req.size() == 0) begin
          chk(1'b0, "R6", "unexpected memory request", mem_req_addr, 32'd0);
        end else begin
          req_t e;
          e = exp_req.pop_front();
          chk(mem_req_write === e.wr, e.req, "direction", 32'(mem_req_write), 32'(e.wr));
          chk(mem_req_addr === e.addr, e.req, "address", mem_req_addr, e.addr);
          chk(mem_req_size === e.size, "R1", "size code", 32'(mem_req_size), 32'(e.size));
          if (e.wr) chk(mem_req_wdata === e.data, e.req, "write data", mem_req_wdata, e.data);
        end
        if (mem_req_write) begin
          for (int k = 0; k < (1 << mem_req_size); k++)
            mem_b[(mem_req_addr + k) & 32'h3ff] = mem_req_wdata[k*8 +: 8];
        end else begin
          rd_pending = 1'b1;
          pend_addr  = mem_req_addr;
        end
      end
      if (rst_n && wb_valid) begin
        if (exp_wb.size() == 0) begin
          chk(1'b0, "R10", "unexpected write-back", 32'(wb_chan), 32'd0);
        end else begin
          wb_t w;
          w = exp_wb.pop_front();
          chk(wb_chan === w.chan, "R10", "wb channel", 32'(wb_chan), 32'(w.chan));
          chk(wb_src === w.src, "R3", "wb source", wb_src, w.src);
          chk(wb_dst === w.dst, "R4", "wb destination", wb_dst, w.dst);
          chk(wb_lli === w.lli, "R7", "wb pointer", wb_lli, w.lli);
          chk(wb_ctrl === w.ctrl, "R5", "wb control", wb_ctrl, w.ctrl);
          chk(wb_en === w.en, "R8", "wb enable", 32'(wb_en), 32'(w.en));
          chk(tc_pulse === w.tc, "R9", "terminal-count pulse", 32'(tc_pulse), 32'(w.tc));
          if (w.tc) chk(tc_chan === w.chan, "R9", "tc channel", 32'(tc_chan), 32'(w.chan));
        end
        wb_seen++;
      end else if (rst_n) begin
        if (tc_pulse !== 1'b0) chk(1'b0, "R9", "pulse outside write-back", 32'(tc_pulse), 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'(wb_seen), 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  localparam logic [31:0] SI = 32'h0400_0000;
  localparam logic [31:0] DI = 32'h0800_0000;
  localparam logic [31:0] TC = 32'h8000_0000;

  function automatic logic [31:0] widths(input int sc, input int dc);
    return (32'(dc) << 21) | (32'(sc) << 18);
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem_b[i] = 8'(i * 7 + 3);
    // descriptors
    put_word(32'h300, 32'h0000_0080);
    put_word(32'h304, 32'h0000_0180);
    put_word(32'h308, 32'h0000_0320);
    put_word(32'h30c, TC | SI | DI | widths(2, 2) | 32'd4);
    put_word(32'h320, 32'h0000_0090);
    put_word(32'h324, 32'h0000_0190);
    put_word(32'h328, 32'h0000_0000);
    put_word(32'h32c, widths(0, 0) | 32'd6);

    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", "reset busy", 32'(busy), 32'd0);
    chk(wb_valid === 1'b0, "R10", "reset write-back", 32'(wb_valid), 32'd0);
    chk(mem_req_valid === 1'b0, "R11", "reset request", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: byte reads packed into a word, upper bits kept
    run(3'd1, 32'h010, 32'h100, 32'h0, 32'h1000_0000 | SI | DI | widths(0, 2) | 32'd3);
    // R4: word read split into byte writes
    run(3'd2, 32'h040, 32'h140, 32'h0, SI | DI | widths(2, 0) | 32'd7);
    // R3 R4: no increments, halfwords, with stalls (R11)
    stall_en = 1'b1;
    run(3'd3, 32'h060, 32'h160, 32'h0, widths(1, 1) | 32'd2);
    // R1: codes above 2 clamp to four bytes
    run(3'd4, 32'h070, 32'h170, 32'h0, SI | DI | widths(7, 5) | 32'd9);
    stall_en = 1'b0;
    // R2: two byte reads into a halfword, destination fixed
    run(3'd5, 32'h0a0, 32'h1a0, 32'h0, SI | widths(0, 1) | 32'd2);
    // R8 R9: last element, no pointer, event requested
    run(3'd6, 32'h0b0, 32'h1b0, 32'h0, TC | SI | DI | widths(2, 2) | 32'd1);
    // R8 R9: last element, no pointer, no event
    run(3'd7, 32'h0c0, 32'h1c0, 32'h0, SI | DI | widths(2, 2) | 32'd1);
    // R7 R9: reload with event in fetched control, stalled port
    stall_en = 1'b1;
    run(3'd0, 32'h0d0, 32'h1d0, 32'h300, SI | DI | widths(2, 2) | 32'd1);
    // R7 R9: reload whose fetched control has no event bit
    run(3'd1, 32'h0e0, 32'h1e0, 32'h320, TC | SI | DI | widths(0, 0) | 32'd1);
    stall_en = 1'b0;
    // R6: count already zero
    run(3'd2, 32'h0f0, 32'h1f0, 32'h300, TC | SI | DI | widths(2, 2) | 32'd0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule